// File: doc/BRIEF.md
# Flash Identification Probe Unit

This block runs the identification probe of a parallel flash device. On a start pulse it has a command sequencer issue a two-write unlock and an ID-mode entry command, then waits a settling time. Next it reads the identification bytes at locations 0 and 1 through a simple read port. A continuation code of 0x7F in either byte makes that ID two bytes long, and the second byte comes from a fixed offset. It then issues the ID-mode exit command, which can take a short or a long form, waits a second settling time, and reads the same locations again. The second pass shows whether the bytes seen in ID mode were really plain array contents.

When the probe completes, the block presents both extended IDs and several flags. The flags report whether both IDs equal the expected manufacturer and device values, whether the manufacturer byte fails an odd-parity check, and, for each ID, whether it equals the post-exit contents. A signed timing setting chooses among caller-given delays, built-in defaults, no delays at all, and refusal to probe. The sequencer owns the bus encoding of each command. This block only selects the command by a two-bit code.

Top module: `fprobe_unit`

## Requirements
- R1: After a start with a usable timing setting, the block issues commands with `cmd_op` codes 0 (first unlock write), 1 (second unlock write) and 2 (ID entry), in that order. It issues each only after the previous one has been acknowledged, and makes no read before the entry command. `cmd_req` and `rd_req` are never high together, and a pending `cmd_req` keeps its `cmd_op` until `cmd_ack`.
- R2: In ID mode the block reads address 0 and then address 1. If the byte from address 0 is 0x7F it then reads 0x100, and if the byte from address 1 is 0x7F it then reads 0x101, in that order. An extended ID is {0x7F, continuation byte}. Otherwise the ID is {0x00, byte}.
- R3: `parity_err` is 1 when the low byte of the final manufacturer ID has an even number of ones.
- R4: After the ID reads, with `long_exit`=1 the block issues codes 0, 1, 3. With `long_exit`=0 it issues code 3 only. It then repeats the read pattern of R2 outside ID mode.
- R5: `mfr_is_array` (or `dev_is_array`) is 1 when the manufacturer (or device) ID read in ID mode equals the value extended from the post-exit reads.
- R6: `id_match` is 1 only when `mfr_id` equals `exp_mfr` and `dev_id` equals `exp_dev`.
- R7: `cfg_timing` is signed. A positive value N sets both the entry delay and the exit delay to N microseconds. The value -1 selects the defaults DFLT_ENTRY_US and DFLT_EXIT_US. The value 0 removes every delay. The entry delay runs from the entry command's acknowledge to the first read, and the exit delay runs from the exit command's acknowledge to the first re-read.
- R8: When delays are enabled, the next command request follows an unlock write's acknowledge by exactly GAP_US microseconds plus one cycle. With delays disabled it follows after one cycle.
- R9: A `cfg_timing` below -1 ends the probe with `done` and `aborted` high on the cycle after start, with no command or read request.
- R10: `done` is high for exactly one cycle with the results valid. The results hold until the next accepted start, and that start clears the IDs to zero.
- R11: A start pulse while a probe is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe (accepted when idle) |
| cfg_timing | input | TIME_W | Signed timing setting |
| long_exit | input | 1 | Use the unlock writes before the ID exit command |
| exp_mfr | input | 16 | Expected manufacturer ID |
| exp_dev | input | 16 | Expected device ID |
| cmd_req | output | 1 | Command request to the sequencer |
| cmd_op | output | 2 | Command code: 0 unlock A, 1 unlock B, 2 ID entry, 3 ID exit |
| cmd_ack | input | 1 | Command accepted by the sequencer |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read offset |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 8 | Read data |
| done | output | 1 | One-cycle completion strobe |
| aborted | output | 1 | Probe refused due to a negative setting |
| mfr_id | output | 16 | Extended manufacturer ID |
| dev_id | output | 16 | Extended device ID |
| id_match | output | 1 | Both IDs equal the expected values |
| parity_err | output | 1 | Manufacturer byte fails odd parity |
| mfr_is_array | output | 1 | Manufacturer ID equals post-exit contents |
| dev_is_array | output | 1 | Device ID equals post-exit contents |

## Verification
A wrong step index or wait count in the controller shows at the command port within one command. It appears as a misordered code, or as a request that comes too early or too late after an acknowledge. The bench measures that spacing to the cycle. A wrong fetch state shows as a read address sequence that departs from the continuation rule during the ID pass or the post-exit pass. A wrong captured value shows up in the IDs or flags on the single `done` cycle. A broken hold shows in the cycles after it.

// File: rtl/fprobe_pkg.sv
package fprobe_pkg;

    typedef enum logic [1:0] {
        OP_UNLOCK_A = 2'd0,
        OP_UNLOCK_B = 2'd1,
        OP_ID_ENTER = 2'd2,
        OP_ID_EXIT  = 2'd3
    } fp_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_WAIT,
        S_FETCH_ID,
        S_FETCH_ARR
    } fp_state_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_RD0,
        F_RD1,
        F_CONT_A,
        F_CONT_B,
        F_HOLD
    } fetch_state_e;

    // odd-parity check: 1 when the byte has an even number of ones
    function automatic logic parity_bad(input logic [7:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/fprobe_timer.sv
module fprobe_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CNT_W'(1));

    // R8: a running count steps down by exactly one per cycle
    p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !load) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/fprobe_fetch.sv
module fprobe_fetch
    import fprobe_pkg::*;
#(
    parameter int          AW        = 16,
    parameter logic [7:0]  CONT_CODE = 8'h7F,
    parameter int          CONT_OFS  = 'h100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          done,
    output logic [15:0]   id_a,
    output logic [15:0]   id_b
);
    typedef struct packed {
        fetch_state_e st;
        logic [7:0]   b0;
        logic [7:0]   b1;
        logic [7:0]   ca;
        logic [7:0]   cb;
        logic         done;
    } fetch_regs_t;

    fetch_regs_t f_d, f_q;

    localparam logic [AW-1:0] ADDR_A  = AW'(0);
    localparam logic [AW-1:0] ADDR_B  = AW'(1);
    localparam logic [AW-1:0] ADDR_CA = AW'(CONT_OFS);
    localparam logic [AW-1:0] ADDR_CB = AW'(CONT_OFS + 1);

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        rd_req   = 1'b0;
        rd_addr  = ADDR_A;
        unique case (f_q.st)
            F_IDLE: begin
                if (run) f_d.st = F_RD0;
            end
            F_RD0: begin
                rd_req  = 1'b1;
                rd_addr = ADDR_A;
                if (rd_ack) begin
                    f_d.b0 = rd_data;
                    f_d.st = F_RD1;
                end
            end
            F_RD1: begin
                rd_req  = 1'b1;
                rd_addr = ADDR_B;
                if (rd_ack) begin
                    f_d.b1 = rd_data;
                    if (f_q.b0 == CONT_CODE) begin
                        f_d.st = F_CONT_A;
                    end else if (rd_data == CONT_CODE) begin
                        f_d.st = F_CONT_B;
                    end else begin
                        f_d.st   = F_HOLD;
                        f_d.done = 1'b1;
                    end
                end
            end
            F_CONT_A: begin
                rd_req  = 1'b1;
                rd_addr = ADDR_CA;
                if (rd_ack) begin
                    f_d.ca = rd_data;
                    if (f_q.b1 == CONT_CODE) begin
                        f_d.st = F_CONT_B;
                    end else begin
                        f_d.st   = F_HOLD;
                        f_d.done = 1'b1;
                    end
                end
            end
            F_CONT_B: begin
                rd_req  = 1'b1;
                rd_addr = ADDR_CB;
                if (rd_ack) begin
                    f_d.cb   = rd_data;
                    f_d.st   = F_HOLD;
                    f_d.done = 1'b1;
                end
            end
            F_HOLD: begin
                if (!run) f_d.st = F_IDLE;
            end
            default: f_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{st: F_IDLE, b0: 8'h00, b1: 8'h00, ca: 8'h00, cb: 8'h00, done: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign done = f_q.done;
    assign id_a = (f_q.b0 == CONT_CODE) ? {f_q.b0, f_q.ca} : {8'h00, f_q.b0};
    assign id_b = (f_q.b1 == CONT_CODE) ? {f_q.b1, f_q.cb} : {8'h00, f_q.b1};

    // R2: a pending read keeps its request and its address until acknowledged
    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

endmodule

// File: rtl/fprobe_unit.sv
module fprobe_unit
    import fprobe_pkg::*;
#(
    parameter int AW            = 16,
    parameter int TIME_W        = 16,
    parameter int CNT_W         = 32,
    parameter int US_CYC        = 1,
    parameter int DFLT_ENTRY_US = 10000,
    parameter int DFLT_EXIT_US  = 40,
    parameter int GAP_US        = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [TIME_W-1:0] cfg_timing,
    input  logic                     long_exit,
    input  logic [15:0]              exp_mfr,
    input  logic [15:0]              exp_dev,
    output logic                     cmd_req,
    output logic [1:0]               cmd_op,
    input  logic                     cmd_ack,
    output logic                     rd_req,
    output logic [AW-1:0]            rd_addr,
    input  logic                     rd_ack,
    input  logic [7:0]               rd_data,
    output logic                     done,
    output logic                     aborted,
    output logic [15:0]              mfr_id,
    output logic [15:0]              dev_id,
    output logic                     id_match,
    output logic                     parity_err,
    output logic                     mfr_is_array,
    output logic                     dev_is_array
);
    localparam logic [CNT_W-1:0] GAP_CYC      = CNT_W'(GAP_US * US_CYC);
    localparam logic [CNT_W-1:0] DFLT_ENT_CYC = CNT_W'(DFLT_ENTRY_US * US_CYC);
    localparam logic [CNT_W-1:0] DFLT_EXT_CYC = CNT_W'(DFLT_EXIT_US * US_CYC);
    localparam logic signed [TIME_W-1:0] T_DEFAULT = -1;
    localparam logic signed [TIME_W-1:0] T_NONE    = 0;
    localparam logic [2:0] STP_ENTER      = 3'd2;
    localparam logic [2:0] STP_EXIT_LONG  = 3'd3;
    localparam logic [2:0] STP_EXIT       = 3'd5;

    typedef struct packed {
        fp_state_e        st;
        logic [2:0]       stp;
        logic [CNT_W-1:0] ent_cyc;
        logic [CNT_W-1:0] ext_cyc;
        logic             dly_en;
        logic             long_ex;
        logic [15:0]      mfr;
        logic [15:0]      dev;
        logic             par;
        logic             m_arr;
        logic             d_arr;
        logic             match;
        logic             done;
        logic             abrt;
    } ctl_regs_t;

    ctl_regs_t c_d, c_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic             fetch_run;
    logic             fetch_done;
    logic [15:0]      fetch_a;
    logic [15:0]      fetch_b;
    logic [CNT_W-1:0] dly_now;
    fp_state_e        adv_st;
    logic [2:0]       adv_stp;
    fp_op_e           op_now;
    logic [CNT_W-1:0] user_cyc;

    fprobe_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    fprobe_fetch #(.AW(AW)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (fetch_run),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .rd_ack  (rd_ack),
        .rd_data (rd_data),
        .done    (fetch_done),
        .id_a    (fetch_a),
        .id_b    (fetch_b)
    );

    // command code and post-command delay for the current step
    always_comb begin
        unique case (c_q.stp)
            3'd0, 3'd3: op_now = OP_UNLOCK_A;
            3'd1, 3'd4: op_now = OP_UNLOCK_B;
            3'd2:       op_now = OP_ID_ENTER;
            default:    op_now = OP_ID_EXIT;
        endcase
        unique case (c_q.stp)
            STP_ENTER: dly_now = c_q.ent_cyc;
            STP_EXIT:  dly_now = c_q.ext_cyc;
            default:   dly_now = c_q.dly_en ? GAP_CYC : '0;
        endcase
        adv_stp = c_q.stp + 3'd1;
        if (c_q.stp == STP_ENTER)     adv_st = S_FETCH_ID;
        else if (c_q.stp == STP_EXIT) adv_st = S_FETCH_ARR;
        else                          adv_st = S_CMD;
        user_cyc = CNT_W'($unsigned(cfg_timing)) * CNT_W'(US_CYC);
    end

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        cmd_req   = 1'b0;
        cmd_op    = OP_UNLOCK_A;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        fetch_run = 1'b0;
        unique case (c_q.st)
            S_IDLE: begin
                if (start) begin
                    c_d.mfr     = '0;
                    c_d.dev     = '0;
                    c_d.par     = 1'b0;
                    c_d.m_arr   = 1'b0;
                    c_d.d_arr   = 1'b0;
                    c_d.match   = 1'b0;
                    c_d.long_ex = long_exit;
                    c_d.stp     = 3'd0;
                    c_d.abrt    = 1'b0;
                    if (cfg_timing < T_DEFAULT) begin
                        c_d.abrt = 1'b1;
                        c_d.done = 1'b1;
                    end else begin
                        c_d.st = S_CMD;
                        if (cfg_timing == T_NONE) begin
                            c_d.dly_en  = 1'b0;
                            c_d.ent_cyc = '0;
                            c_d.ext_cyc = '0;
                        end else if (cfg_timing == T_DEFAULT) begin
                            c_d.dly_en  = 1'b1;
                            c_d.ent_cyc = DFLT_ENT_CYC;
                            c_d.ext_cyc = DFLT_EXT_CYC;
                        end else begin
                            c_d.dly_en  = 1'b1;
                            c_d.ent_cyc = user_cyc;
                            c_d.ext_cyc = user_cyc;
                        end
                    end
                end
            end
            S_CMD: begin
                cmd_req = 1'b1;
                cmd_op  = op_now;
                if (cmd_ack) begin
                    if (dly_now != '0) begin
                        tmr_load = 1'b1;
                        tmr_val  = dly_now;
                        c_d.st   = S_WAIT;
                    end else begin
                        c_d.st  = adv_st;
                        c_d.stp = adv_stp;
                    end
                end
            end
            S_WAIT: begin
                if (tmr_last) begin
                    c_d.st  = adv_st;
                    c_d.stp = adv_stp;
                end
            end
            S_FETCH_ID: begin
                fetch_run = 1'b1;
                if (fetch_done) begin
                    c_d.mfr = fetch_a;
                    c_d.dev = fetch_b;
                    c_d.par = parity_bad(fetch_a[7:0]);
                    c_d.stp = c_q.long_ex ? STP_EXIT_LONG : STP_EXIT;
                    c_d.st  = S_CMD;
                end
            end
            S_FETCH_ARR: begin
                fetch_run = 1'b1;
                if (fetch_done) begin
                    c_d.m_arr = (c_q.mfr == fetch_a);
                    c_d.d_arr = (c_q.dev == fetch_b);
                    c_d.match = (c_q.mfr == exp_mfr) && (c_q.dev == exp_dev);
                    c_d.done  = 1'b1;
                    c_d.st    = S_IDLE;
                end
            end
            default: c_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: S_IDLE, stp: 3'd0, ent_cyc: '0, ext_cyc: '0, dly_en: 1'b0,
                     long_ex: 1'b0, mfr: 16'h0, dev: 16'h0, par: 1'b0, m_arr: 1'b0,
                     d_arr: 1'b0, match: 1'b0, done: 1'b0, abrt: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign done         = c_q.done;
    assign aborted      = c_q.abrt;
    assign mfr_id       = c_q.mfr;
    assign dev_id       = c_q.dev;
    assign id_match     = c_q.match;
    assign parity_err   = c_q.par;
    assign mfr_is_array = c_q.m_arr;
    assign dev_is_array = c_q.d_arr;

    // R1: command and read requests never overlap
    p_one_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_req && rd_req));

    // R1: a pending command holds its request and code until acknowledged
    p_cmd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op)));

    // R10: completion is a single-cycle strobe
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a refused probe shows no bus activity on its completion cycle
    p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && aborted) |-> (!cmd_req && !rd_req));

endmodule

// File: tb/fprobe_unit_bench.sv
module fprobe_unit_bench;
    localparam int AW = 16;
    localparam int US = 2;
    localparam int DE = 100;
    localparam int DX = 7;
    localparam int GP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [15:0] cfg_timing = '0;
    logic long_exit = 1'b0;
    logic [15:0] exp_mfr = '0, exp_dev = '0;
    logic cmd_req, cmd_ack = 1'b0;
    logic [1:0] cmd_op;
    logic rd_req, rd_ack = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [7:0] rd_data = '0;
    logic done, aborted, id_match, parity_err, mfr_is_array, dev_is_array;
    logic [15:0] mfr_id, dev_id;

    always #5 clk = ~clk;

    fprobe_unit #(.AW(AW), .US_CYC(US), .DFLT_ENTRY_US(DE), .DFLT_EXIT_US(DX),
                  .GAP_US(GP)) u_fprobe_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_timing(cfg_timing),
        .long_exit(long_exit), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
        .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_ack(cmd_ack),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .done(done), .aborted(aborted), .mfr_id(mfr_id), .dev_id(dev_id),
        .id_match(id_match), .parity_err(parity_err),
        .mfr_is_array(mfr_is_array), .dev_is_array(dev_is_array));

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // flash + sequencer model: ID bytes and array bytes at 0,1,0x100,0x101
    logic [7:0] idb [4];
    logic [7:0] arb [4];
    bit in_id = 0;
    int n_ops = 0, n_rd = 0;
    int op_code [16];
    int op_seen [16];
    int op_acc  [16];
    int rd_log  [16];
    int rd_seen [16];
    int rd_mode [16];
    bit c_busy = 0, r_busy = 0;
    int c_lat = 0, r_lat = 0;

    function automatic int slot(input logic [AW-1:0] a);
        case (a)
            16'h0000: return 0;
            16'h0001: return 1;
            16'h0100: return 2;
            16'h0101: return 3;
            default:  return -1;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            cmd_ack = 0; rd_ack = 0; c_busy = 0; r_busy = 0;
        end else begin
            cmd_ack = 0;
            if (cmd_req) begin
                if (!c_busy) begin
                    c_busy = 1; c_lat = $urandom % 3;
                    if (n_ops < 16) op_seen[n_ops] = cyc;
                end
                if (c_lat == 0) begin
                    cmd_ack = 1; c_busy = 0;
                    if (n_ops < 16) begin
                        op_code[n_ops] = int'(cmd_op); op_acc[n_ops] = cyc;
                    end
                    n_ops++;
                    if (cmd_op == 2'd2) in_id = 1;
                    if (cmd_op == 2'd3) in_id = 0;
                end else c_lat--;
            end
            rd_ack = 0;
            if (rd_req) begin
                if (!r_busy) begin
                    r_busy = 1; r_lat = $urandom % 3;
                    if (n_rd < 16) rd_seen[n_rd] = cyc;
                end
                if (r_lat == 0) begin
                    int s;
                    s = slot(rd_addr);
                    rd_ack = 1; r_busy = 0;
                    rd_data = (s < 0) ? 8'hFF : (in_id ? idb[s] : arb[s]);
                    if (n_rd < 16) begin
                        rd_log[n_rd] = int'(rd_addr); rd_mode[n_rd] = int'(in_id);
                    end
                    n_rd++;
                end else r_lat--;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ext_id(input logic [7:0] b, input logic [7:0] c);
        return (b == 8'h7F) ? {b, c} : {8'h00, b};
    endfunction

    // expected read-address list for one pass
    function automatic int exp_reads(input logic [7:0] b0, input logic [7:0] b1,
                                     output int lst [4]);
        int n = 2;
        lst[0] = 0; lst[1] = 1;
        if (b0 == 8'h7F) begin lst[n] = 'h100; n++; end
        if (b1 == 8'h7F) begin lst[n] = 'h101; n++; end
        return n;
    endfunction

    task automatic run_probe(input int t, input bit lng, input bit extra_start);
        logic [15:0] e_m, e_d, a_m, a_d;
        int ent, ext, gap, k, nid, nar, nexp, first_arr;
        int l_id [4];
        int l_ar [4];
        int exp_ops [6];
        bit abort_case;
        abort_case = (t < -1);
        e_m = ext_id(idb[0], idb[2]); e_d = ext_id(idb[1], idb[3]);
        a_m = ext_id(arb[0], arb[2]); a_d = ext_id(arb[1], arb[3]);
        if (t == 0)       begin ent = 0; ext = 0; gap = 0; end
        else if (t == -1) begin ent = DE*US; ext = DX*US; gap = GP*US; end
        else              begin ent = t*US; ext = t*US; gap = GP*US; end
        n_ops = 0; n_rd = 0;
        @(negedge clk);
        cfg_timing = 16'(t); long_exit = lng; start = 1;
        @(negedge clk);
        start = 0;
        chk(mfr_id == 16'h0 && dev_id == 16'h0, "R10", "ids cleared at start", mfr_id, 0);
        if (extra_start) begin
            repeat (3) @(negedge clk);
            start = 1; @(negedge clk); start = 0;
        end
        k = 0;
        while (!done && k < 20000) begin @(negedge clk); k++; end
        chk(done, "R10", "done seen", int'(done), 1);
        if (abort_case) begin
            chk(aborted && n_ops == 0 && n_rd == 0, "R9", "refused with no bus use",
                n_ops + n_rd, 0);
            chk(k == 0, "R9", "refusal latency", k, 0);
        end else begin
            chk(!aborted, "R9", "not aborted", int'(aborted), 0);
            chk(mfr_id == e_m, "R2", "manufacturer id", mfr_id, e_m);
            chk(dev_id == e_d, "R2", "device id", dev_id, e_d);
            chk(parity_err == ~^e_m[7:0], "R3", "parity flag", parity_err, ~^e_m[7:0]);
            chk(mfr_is_array == (e_m == a_m), "R5", "mfr array flag", mfr_is_array, e_m == a_m);
            chk(dev_is_array == (e_d == a_d), "R5", "dev array flag", dev_is_array, e_d == a_d);
            chk(id_match == (e_m == exp_mfr && e_d == exp_dev), "R6", "match flag",
                id_match, e_m == exp_mfr && e_d == exp_dev);
            // command sequence
            exp_ops[0] = 0; exp_ops[1] = 1; exp_ops[2] = 2;
            if (lng) begin exp_ops[3] = 0; exp_ops[4] = 1; exp_ops[5] = 3; nexp = 6; end
            else     begin exp_ops[3] = 3; nexp = 4; end
            chk(n_ops == nexp, extra_start ? "R11" : "R4", "command count", n_ops, nexp);
            for (int i = 0; i < nexp && i < n_ops; i++)
                chk(op_code[i] == exp_ops[i], i < 3 ? "R1" : "R4", "command code",
                    op_code[i], exp_ops[i]);
            // gaps after unlock writes
            for (int i = 0; i + 1 < nexp && i + 1 < n_ops; i++)
                if (exp_ops[i] < 2)
                    chk(op_seen[i+1] - op_acc[i] == gap + 1, "R8", "unlock spacing",
                        op_seen[i+1] - op_acc[i], gap + 1);
            // reads
            nid = exp_reads(idb[0], idb[1], l_id);
            nar = exp_reads(arb[0], arb[1], l_ar);
            chk(n_rd == nid + nar, "R2", "read count", n_rd, nid + nar);
            for (int i = 0; i < nid && i < n_rd; i++)
                chk(rd_log[i] == l_id[i] && rd_mode[i] == 1, "R2", "ID read address",
                    rd_log[i], l_id[i]);
            for (int i = 0; i < nar && nid + i < n_rd; i++)
                chk(rd_log[nid+i] == l_ar[i] && rd_mode[nid+i] == 0, "R4",
                    "re-read address", rd_log[nid+i], l_ar[i]);
            if (n_rd > 0 && n_ops >= 3)
                chk(rd_seen[0] - op_acc[2] >= ent + 1 && rd_seen[0] - op_acc[2] <= ent + 3,
                    "R7", "entry delay", rd_seen[0] - op_acc[2], ent + 2);
            first_arr = nid;
            if (n_rd > first_arr && n_ops == nexp)
                chk(rd_seen[first_arr] - op_acc[nexp-1] >= ext + 1 &&
                    rd_seen[first_arr] - op_acc[nexp-1] <= ext + 3,
                    "R7", "exit delay", rd_seen[first_arr] - op_acc[nexp-1], ext + 2);
        end
        @(negedge clk);
        chk(!done, "R10", "done one cycle", int'(done), 0);
        repeat (4) @(negedge clk);
        if (!abort_case)
            chk(mfr_id == e_m && dev_id == e_d, "R10", "results held", mfr_id, e_m);
    endtask

    task automatic rand_data();
        for (int i = 0; i < 4; i++) begin
            idb[i] = 8'($urandom);
            arb[i] = 8'($urandom);
        end
        if ($urandom % 3 == 0) idb[0] = 8'h7F;
        if ($urandom % 3 == 0) idb[1] = 8'h7F;
        if ($urandom % 3 == 0) arb = idb;
        if ($urandom % 2 == 0) begin
            exp_mfr = ext_id(idb[0], idb[2]); exp_dev = ext_id(idb[1], idb[3]);
            if ($urandom % 3 == 0) exp_dev = exp_dev ^ 16'h0001;
        end else begin
            exp_mfr = 16'($urandom); exp_dev = 16'($urandom);
        end
    endtask

    bit finished = 0;
    initial begin
        #(150000 * 10);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(!done && !cmd_req && !rd_req && mfr_id == 0 && !id_match, "R10",
            "reset state", int'(done), 0);
        rst_n = 1;
        @(negedge clk);
        // directed: no continuation, odd-parity manufacturer, exact match
        idb = '{8'h01, 8'hA4, 8'h00, 8'h00}; arb = '{8'h11, 8'h22, 8'h33, 8'h44};
        exp_mfr = 16'h0001; exp_dev = 16'h00A4;
        run_probe(0, 0, 0);
        // directed: both continuation, even parity on final byte, array-like data
        idb = '{8'h7F, 8'h7F, 8'h03, 8'h9D}; arb = idb;
        exp_mfr = 16'h7F03; exp_dev = 16'h0000;
        run_probe(-1, 1, 0);
        // directed: only second ID extended, positive timing
        idb = '{8'hBF, 8'h7F, 8'h55, 8'h42}; arb = '{8'hBF, 8'h00, 8'h00, 8'h00};
        exp_mfr = 16'h00BF; exp_dev = 16'h7F42;
        run_probe(5, 1, 0);
        // directed: refusal for a negative setting
        run_probe(-2, 0, 0);
        // directed: start pulse while running is ignored (R11)
        rand_data();
        run_probe(4, 0, 1);
        // random mix
        for (int r = 0; r < 40; r++) begin
            int sel, t;
            rand_data();
            sel = $urandom % 8;
            if (sel == 0)      t = -2 - int'($urandom % 5);
            else if (sel == 1) t = 0;
            else if (sel == 2) t = -1;
            else               t = 1 + int'($urandom % 15);
            run_probe(t, bit'($urandom % 2), 0);
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule